// File: doc/BRIEF.md
# Sector Sync Framer

This block divides a continuous stream of 16-bit words from a disc decoder into fixed sectors of 1176 words (2352 bytes). A running word index gives the position of each incoming word inside the current sector. A pattern matcher watches the stream for the six-word sector sync mark. A fill-in mechanism supplies a boundary when the mark fails to arrive where it is due.

Three static controls shape the behaviour. One turns the pattern matcher on or off. One turns boundary insertion on or off. The third chooses whether a mark found at the wrong position moves the framing to that position or is only noted.

At each boundary the block emits a one-cycle strobe and refreshes four status flags that describe how that boundary, or the current sector so far, was formed. Downstream framing logic uses the strobe and the index to place the sector header and payload.

Top module: `sector_framer`

## Requirements
- R1: After reset the word index is 0, the strobe is low and all four flags are low.
- R2: The word index advances by one for each cycle with `word_valid` high. It holds when `word_valid` is low.
- R3: The sync mark is the word sequence 0x00FF, 0xFFFF, 0xFFFF, 0xFFFF, 0xFFFF, 0xFF00, in arrival order. When its last word arrives at index 1175, the strobe pulses, the index returns to 0 and all flags read 0.
- R4: When the word at index 1175 does not complete a mark and insertion is enabled, a boundary is inserted. The strobe pulses, the index returns to 0 and `flag_inserted` reads 1.
- R5: When the mark completes at any index other than 1175, with detection and retiming enabled, the framing moves to it. The strobe pulses, the index returns to 0 and `flag_insync` reads 1.
- R6: With insertion disabled and no mark at index 1175, `flag_long` is set and the index keeps counting past 1175 without wrapping. It saturates at 4095.
- R7: When the mark completes at an index other than 1175 with detection enabled and retiming disabled, `flag_short` is set. No strobe occurs and the index keeps counting.
- R8: With detection disabled, a complete mark has no effect. It causes no strobe, sets no flag and does not change the index sequence.
- R9: The strobe lasts exactly one cycle. At the strobe, `flag_insync` and `flag_inserted` take the kind of that boundary, and `flag_long` and `flag_short` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A stream word is present this cycle |
| word_in | input | 16 | Stream word |
| detect_en | input | 1 | Enable the sync pattern matcher |
| interp_en | input | 1 | Enable boundary insertion at the expected position |
| retime_en | input | 1 | Move framing to a misplaced sync mark |
| sector_start | output | 1 | One-cycle strobe at each accepted or inserted boundary |
| word_idx | output | 12 | Index of the next word within the sector |
| flag_insync | output | 1 | Last boundary came from a misplaced mark |
| flag_inserted | output | 1 | Last boundary was inserted |
| flag_long | output | 1 | Current sector ran past its expected length |
| flag_short | output | 1 | Current sector held a misplaced mark that was not followed |

## Verification
A fault in the word counter shows up as a wrong `word_idx` on the very next valid word. It also moves every later strobe, so a miscount appears both at once and 1176 words later. A fault in the pattern history or the position compare shows up as a missing, extra or misplaced strobe in the cycle after the mark's last word, with the wrong flag raised. A fault in flag updating is visible in the cycle after the boundary or event that should change the flag, and it stays visible until the next strobe.

// File: rtl/sector_framer.sv
module sector_framer #(
  parameter int SECTOR_WORDS = 1176
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  word_valid,
  input  logic [15:0]                           word_in,
  input  logic                                  detect_en,
  input  logic                                  interp_en,
  input  logic                                  retime_en,
  output logic                                  sector_start,
  output logic [$clog2(SECTOR_WORDS):0]         word_idx,
  output logic                                  flag_insync,
  output logic                                  flag_inserted,
  output logic                                  flag_long,
  output logic                                  flag_short
);
  localparam int CW = $clog2(SECTOR_WORDS) + 1;
  localparam logic [CW-1:0] LAST = CW'(SECTOR_WORDS - 1);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [15:0] MARK_HEAD = 16'h00FF;
  localparam logic [15:0] MARK_BODY = 16'hFFFF;
  localparam logic [15:0] MARK_TAIL = 16'hFF00;

  logic [4:0][15:0] hist;

  wire pattern = (word_in == MARK_TAIL) && (hist[0] == MARK_BODY) &&
                 (hist[1] == MARK_BODY) && (hist[2] == MARK_BODY) &&
                 (hist[3] == MARK_BODY) && (hist[4] == MARK_HEAD);

  wire hit          = word_valid && detect_en && pattern;
  wire at_last      = (word_idx == LAST);
  wire take_inplace = hit && at_last;
  wire take_retime  = hit && !at_last && retime_en;
  wire take_insert  = word_valid && at_last && !hit && interp_en;
  wire boundary     = take_inplace || take_retime || take_insert;
  wire set_long     = word_valid && at_last && !hit && !interp_en;
  wire set_short    = hit && !at_last && !retime_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist          <= '0;
      word_idx      <= '0;
      sector_start  <= 1'b0;
      flag_insync   <= 1'b0;
      flag_inserted <= 1'b0;
      flag_long     <= 1'b0;
      flag_short    <= 1'b0;
    end else begin
      sector_start <= boundary;
      if (word_valid) hist <= {hist[3:0], word_in};
      if (boundary) begin
        word_idx      <= '0;
        flag_insync   <= take_retime;
        flag_inserted <= take_insert;
        flag_long     <= 1'b0;
        flag_short    <= 1'b0;
      end else if (word_valid) begin
        if (word_idx != CNT_MAX) word_idx <= word_idx + 1'b1;
        if (set_long)  flag_long  <= 1'b1;
        if (set_short) flag_short <= 1'b1;
      end
    end
  end

  assert_strobe_idx_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sector_start |-> (word_idx == '0));
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sector_start |=> !sector_start);
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(word_idx));
  assert_kind_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_insync, flag_inserted}));
  assert_insert_at_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_inserted) |-> sector_start);
  assert_long_needs_no_interp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_long) |-> !$past(interp_en));
  assert_short_needs_detect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_short) |-> $past(detect_en));
  assert_retime_needs_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_insync) |-> $past(detect_en));
endmodule

// File: tb/sim_sector_framer.sv
module sim_sector_framer;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, word_valid, detect_en, interp_en, retime_en;
  logic [15:0] word_in;
  logic sector_start, flag_insync, flag_inserted, flag_long, flag_short;
  logic [11:0] word_idx;

  int checks = 0;
  int fails  = 0;
  int strobes;

  always #(PERIOD/2) clk = ~clk;

  sector_framer u0 (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
    .detect_en(detect_en), .interp_en(interp_en), .retime_en(retime_en),
    .sector_start(sector_start), .word_idx(word_idx),
    .flag_insync(flag_insync), .flag_inserted(flag_inserted),
    .flag_long(flag_long), .flag_short(flag_short));

  typedef struct packed {
    logic       det;
    logic       itp;
    logic       ret;
    logic       has_sync;
    logic [11:0] pos;
    logic [12:0] nfill;
    logic [11:0] exp_idx;
    logic [3:0]  exp_flags;
    logic [1:0]  exp_strobes;
  } vec_t;

  localparam vec_t TABLE [12] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'd1175, 13'd0,    12'd0,    4'b0000, 2'd1}, // R3
    '{1'b1, 1'b1, 1'b1, 1'b0, 12'd0,    13'd1176, 12'd0,    4'b0100, 2'd1}, // R4
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'd600,  13'd0,    12'd0,    4'b1000, 2'd1}, // R5
    '{1'b1, 1'b1, 1'b0, 1'b1, 12'd600,  13'd0,    12'd601,  4'b0001, 2'd0}, // R7
    '{1'b0, 1'b1, 1'b1, 1'b1, 12'd600,  13'd0,    12'd601,  4'b0000, 2'd0}, // R8
    '{1'b1, 1'b0, 1'b1, 1'b0, 12'd0,    13'd1180, 12'd1180, 4'b0010, 2'd0}, // R6
    '{1'b1, 1'b0, 1'b1, 1'b1, 12'd1180, 13'd0,    12'd0,    4'b1000, 2'd1}, // R5 late, R9 clears long
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'd5,    13'd0,    12'd0,    4'b1000, 2'd1}, // R5 earliest
    '{1'b0, 1'b0, 1'b0, 1'b0, 12'd0,    13'd1200, 12'd1200, 4'b0010, 2'd0}, // R6
    '{1'b0, 1'b1, 1'b1, 1'b1, 12'd1175, 13'd0,    12'd0,    4'b0100, 2'd1}, // R8 with R4
    '{1'b1, 1'b1, 1'b0, 1'b1, 12'd1175, 13'd0,    12'd0,    4'b0000, 2'd1}, // R3 no retime
    '{1'b0, 1'b0, 1'b1, 1'b0, 12'd0,    13'd4100, 12'd4095, 4'b0010, 2'd0}  // R6 saturate
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    word_valid = 1'b1;
    word_in    = w;
    @(negedge clk);
    if (sector_start) strobes++;
  endtask

  task automatic idle();
    word_valid = 1'b0;
    word_in    = 16'h0;
    @(negedge clk);
    if (sector_start) strobes++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    word_valid = 1'b0;
    word_in = 16'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    strobes = 0;
  endtask

  task automatic send_mark();
    send(16'h00FF);
    for (int k = 0; k < 4; k++) send(16'hFFFF);
    send(16'hFF00);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    detect_en = 1'b1; interp_en = 1'b1; retime_en = 1'b1;
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 idx", int'(word_idx), 0);
    check("R1 strobe", int'(sector_start), 0);
    check("R1 insync", int'(flag_insync), 0);
    check("R1 inserted", int'(flag_inserted), 0);
    check("R1 long", int'(flag_long), 0);
    check("R1 short", int'(flag_short), 0);

    // R2 gaps between words
    send(16'h1111); idle(); idle();
    send(16'h2222); idle();
    send(16'h3333);
    check("R2 idx after gaps", int'(word_idx), 3);
    repeat (4) idle();
    check("R2 idx held while idle", int'(word_idx), 3);

    for (int v = 0; v < 12; v++) begin
      detect_en = TABLE[v].det;
      interp_en = TABLE[v].itp;
      retime_en = TABLE[v].ret;
      do_reset();
      if (TABLE[v].has_sync) begin
        for (int f = 0; f < int'(TABLE[v].pos) - 5; f++) send(16'h1234);
        send_mark();
      end else begin
        for (int f = 0; f < int'(TABLE[v].nfill); f++) send(16'h1234);
      end
      idle();
      check($sformatf("vec%0d idx", v), int'(word_idx), int'(TABLE[v].exp_idx));
      check($sformatf("vec%0d insync", v), int'(flag_insync), int'(TABLE[v].exp_flags[3]));
      check($sformatf("vec%0d inserted", v), int'(flag_inserted), int'(TABLE[v].exp_flags[2]));
      check($sformatf("vec%0d long", v), int'(flag_long), int'(TABLE[v].exp_flags[1]));
      check($sformatf("vec%0d short", v), int'(flag_short), int'(TABLE[v].exp_flags[0]));
      check($sformatf("vec%0d strobes R9", v), strobes, int'(TABLE[v].exp_strobes));
      check($sformatf("vec%0d strobe low after R9", v), int'(sector_start), 0);
    end

    // R9: short flag cleared by the following inserted boundary
    detect_en = 1'b1; interp_en = 1'b1; retime_en = 1'b0;
    do_reset();
    for (int f = 0; f < 595; f++) send(16'h1234);
    send_mark();
    check("R7 short set mid-sector", int'(flag_short), 1);
    for (int f = 601; f < 1176; f++) send(16'h1234);
    idle();
    check("R9 short cleared at strobe", int'(flag_short), 0);
    check("R9 inserted at strobe", int'(flag_inserted), 1);
    check("R9 single strobe", strobes, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule